// File: doc/BRIEF.md
# Addend-Compensated Nanosecond Time Counter

This block keeps a free-running 64-bit time of day in nanoseconds for precision time protocol work. It runs from a system clock that is faster than the nominal timer tick. On every system clock cycle a 32-bit fractional phase accumulator adds a programmable addend. Each carry out of that accumulator counts as one timer tick, and each tick advances the time by a programmable tick period in nanoseconds. The nominal addend is ceil(2^32 / R), where R is the system clock rate divided by the nominal tick rate (R > 1). Raising the addend above nominal speeds the clock up. The headroom for this, in parts per billion, is 1e9 × (R − 1) − 1. For example, a 10 ns tick with addend 0x999999A4 corresponds to R of about 1.667.

Software reaches the block through a flat register port with write enable, read enable, a 4-bit word address and 32-bit data. It can trim the addend, change the tick period, load a new time and read the running time coherently. Two external event inputs are synchronized and time-stamped on their rising edges. A single alarm comparator raises an interrupt once when the time reaches a programmed value. The alarm is a three-state machine. From AL_OFF, an alarm write (arm) leads to AL_ARMED. From AL_ARMED, the time reaching the alarm value (reach) leads to AL_FIRED, and a fresh arm stays in AL_ARMED. From AL_FIRED, an acknowledge (ack) leads back to AL_OFF, and an arm leads to AL_ARMED. The interrupt output is high exactly in AL_FIRED.

Top module: `tod_addend_counter`

## Requirements
- R1: After reset the time reads 0, the accumulator is 0, the interrupt is low, the addend register (address 0x0) reads 0x999999A4, the tick register (address 0x1) reads 10, and status (address 0x6) reads 0.
- R2: On every system clock cycle the accumulator becomes (accumulator + addend) mod 2^32. The time advances by the tick period on exactly the cycles whose sum carries out of bit 31, and is unchanged on every other cycle.
- R3: A write to the addend (address 0x0) is used from the following cycle on. The accumulator remainder is kept across the write.
- R4: A write to the tick period (address 0x1, low 8 bits) changes the step applied on later carries.
- R5: A write to address 0x2 stages the low word of a new time. A write to address 0x3 loads {written word, staged low word} into the time in one step and clears the accumulator.
- R6: Reading address 0x2 returns the live low time word and freezes the high word. Reading address 0x3 then returns that frozen high word, even if the time has since carried into the high half.
- R7: Each event input passes through two synchronizing flops. A rising edge stores the 64-bit time into its capture registers (event i: low word at 0x8+2i, high word at 0x9+2i) and sets status bit i. A level that stays high does not capture again.
- R8: Writing status (address 0x6) with bit i set clears event flag i. Flags whose bits are written 0 are unchanged.
- R9: A write to address 0x4 stages the low word of the alarm. A write to address 0x5 sets the alarm to {written word, staged low word} and arms it. While armed, the first cycle on which the time is greater than or equal to the alarm moves to the fired state. The interrupt and status bit 2 stay high from then on.
- R10: Writing status with bit 2 set while fired lowers the interrupt. The alarm does not fire again, even though the time still meets the alarm value.
- R11: A write to address 0x5 re-arms the alarm from any state and lowers the interrupt. An alarm value already in the past fires on the next cycle. Addresses 0x4 and 0x5 read back the alarm value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (freezes the high time word on a low-word read) |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| evt_in | input | 2 | Asynchronous external event inputs |
| time_ns | output | 64 | Running time in nanoseconds |
| alarm_irq | output | 1 | Alarm interrupt, high in the fired state |

## Verification
On every cycle, the assertions check the following. Outside a load the time moves by either zero or exactly one tick period. A load places the staged value in the time on the next cycle. The interrupt rises only when the previous time met the alarm, and once high it stays high until an acknowledge or an arm. Event flags persist until written clear. Other behaviour can only be shown by the bench's scenarios: the exact carry pattern of the fractional accumulator, keeping the remainder across an addend write, the frozen high word across a low-word wrap, the capture latency through the synchronizer, and the single fire after an acknowledge. The bench runs these scenarios against a behavioural model that it compares every cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] RA_ADDEND   = 4'h0;
    localparam logic [ADDR_W-1:0] RA_TICK     = 4'h1;
    localparam logic [ADDR_W-1:0] RA_TIME_LO  = 4'h2;
    localparam logic [ADDR_W-1:0] RA_TIME_HI  = 4'h3;
    localparam logic [ADDR_W-1:0] RA_ALARM_LO = 4'h4;
    localparam logic [ADDR_W-1:0] RA_ALARM_HI = 4'h5;
    localparam logic [ADDR_W-1:0] RA_STATUS   = 4'h6;
    localparam int                RA_CAP_BASE = 8;

    typedef enum logic [1:0] {
        AL_OFF   = 2'd0,
        AL_ARMED = 2'd1,
        AL_FIRED = 2'd2
    } alarm_state_e;
endpackage

// File: rtl/tod_phase_accum.sv
module tod_phase_accum #(
    parameter int ACC_W  = 32,
    parameter int TIME_W = 64,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  addend,
    input  logic [TICK_W-1:0] tick,
    input  logic              load_en,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] time_q
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, addend};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            time_q <= '0;
        end else if (load_en) begin
            acc_q  <= '0;
            time_q <= load_val;
        end else begin
            acc_q <= sum[ACC_W-1:0];
            if (sum[ACC_W]) begin
                time_q <= time_q + TIME_W'(tick);
            end
        end
    end
endmodule

// File: rtl/tod_event_capture.sv
module tod_event_capture #(
    parameter int TIME_W = 64,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_in,
    input  logic [TIME_W-1:0] time_now,
    input  logic              clr,
    output logic [TIME_W-1:0] cap_q,
    output logic              flag_q
);
    localparam int PIPE_W = SYNC_N + 1;

    logic [PIPE_W-1:0] pipe_q;
    logic              rise;

    assign rise = pipe_q[SYNC_N-1] & ~pipe_q[SYNC_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            pipe_q <= {pipe_q[PIPE_W-2:0], evt_in};
            if (rise) begin
                cap_q <= time_now;
            end
            flag_q <= rise | (flag_q & ~clr);
        end
    end
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [TIME_W-1:0] arm_val,
    input  logic              ack,
    input  logic [TIME_W-1:0] time_now,
    output logic [TIME_W-1:0] alarm_q,
    output logic              fired
);
    alarm_state_e state_q, state_d;
    logic         reach;

    assign reach = (time_now >= alarm_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AL_OFF;
            alarm_q <= '0;
        end else begin
            state_q <= state_d;
            if (arm) begin
                alarm_q <= arm_val;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_OFF: begin
                if (arm) state_d = AL_ARMED;
            end
            AL_ARMED: begin
                if (arm)        state_d = AL_ARMED;
                else if (reach) state_d = AL_FIRED;
            end
            AL_FIRED: begin
                if (arm)      state_d = AL_ARMED;
                else if (ack) state_d = AL_OFF;
            end
            default: state_d = AL_OFF;
        endcase
    end

    always_comb begin
        fired = 1'b0;
        unique case (state_q)
            AL_FIRED: fired = 1'b1;
            default:  fired = 1'b0;
        endcase
    end
endmodule

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter int              BUS_W      = 32,
    parameter int              TICK_W     = 8,
    parameter int              NUM_EVT    = 2,
    parameter logic [BUS_W-1:0] ADDEND_RST = 32'h9999_99A4,
    parameter int              TICK_RST   = 10
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [BUS_W-1:0]                 wdata,
    output logic [BUS_W-1:0]                 rdata,
    input  logic [2*BUS_W-1:0]               time_now,
    input  logic [2*BUS_W-1:0]               alarm_val,
    input  logic                             alarm_fired,
    input  logic [NUM_EVT-1:0][2*BUS_W-1:0]  caps,
    input  logic [NUM_EVT-1:0]               flags,
    output logic [BUS_W-1:0]                 addend_q,
    output logic [TICK_W-1:0]                tick_q,
    output logic                             load_en,
    output logic [2*BUS_W-1:0]               load_val,
    output logic                             arm,
    output logic [2*BUS_W-1:0]               arm_val,
    output logic                             ack,
    output logic [NUM_EVT-1:0]               evt_clr
);
    localparam int TIME_W = 2 * BUS_W;

    logic [BUS_W-1:0] load_lo_q;
    logic [BUS_W-1:0] alarm_lo_q;
    logic [BUS_W-1:0] snap_hi_q;
    logic             status_wr;

    assign status_wr = wr_en && (addr == RA_STATUS);
    assign load_en   = wr_en && (addr == RA_TIME_HI);
    assign load_val  = {wdata, load_lo_q};
    assign arm       = wr_en && (addr == RA_ALARM_HI);
    assign arm_val   = {wdata, alarm_lo_q};
    assign ack       = status_wr && wdata[NUM_EVT];
    assign evt_clr   = status_wr ? wdata[NUM_EVT-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addend_q   <= ADDEND_RST;
            tick_q     <= TICK_W'(TICK_RST);
            load_lo_q  <= '0;
            alarm_lo_q <= '0;
            snap_hi_q  <= '0;
        end else begin
            if (wr_en && addr == RA_ADDEND)   addend_q   <= wdata;
            if (wr_en && addr == RA_TICK)     tick_q     <= wdata[TICK_W-1:0];
            if (wr_en && addr == RA_TIME_LO)  load_lo_q  <= wdata;
            if (wr_en && addr == RA_ALARM_LO) alarm_lo_q <= wdata;
            if (rd_en && addr == RA_TIME_LO)  snap_hi_q  <= time_now[TIME_W-1:BUS_W];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_ADDEND:   rdata = addend_q;
            RA_TICK:     rdata = BUS_W'(tick_q);
            RA_TIME_LO:  rdata = time_now[BUS_W-1:0];
            RA_TIME_HI:  rdata = snap_hi_q;
            RA_ALARM_LO: rdata = alarm_val[BUS_W-1:0];
            RA_ALARM_HI: rdata = alarm_val[TIME_W-1:BUS_W];
            RA_STATUS:   rdata = BUS_W'({alarm_fired, flags});
            default: begin
                for (int i = 0; i < NUM_EVT; i++) begin
                    if (addr == ADDR_W'(RA_CAP_BASE + 2 * i))
                        rdata = caps[i][BUS_W-1:0];
                    if (addr == ADDR_W'(RA_CAP_BASE + 2 * i + 1))
                        rdata = caps[i][TIME_W-1:BUS_W];
                end
            end
        endcase
    end
endmodule

// File: rtl/tod_addend_counter.sv
module tod_addend_counter
    import tod_pkg::*;
#(
    parameter int               BUS_W      = 32,
    parameter int               TICK_W     = 8,
    parameter int               NUM_EVT    = 2,
    parameter logic [BUS_W-1:0] ADDEND_RST = 32'h9999_99A4,
    parameter int               TICK_RST   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BUS_W-1:0]     wdata,
    output logic [BUS_W-1:0]     rdata,
    input  logic [NUM_EVT-1:0]   evt_in,
    output logic [2*BUS_W-1:0]   time_ns,
    output logic                 alarm_irq
);
    localparam int TIME_W = 2 * BUS_W;
    localparam int ACC_W  = BUS_W;

    logic [ACC_W-1:0]                addend_w;
    logic [TICK_W-1:0]               tick_w;
    logic                            load_en_w;
    logic [TIME_W-1:0]               load_val_w;
    logic                            arm_w;
    logic [TIME_W-1:0]               arm_val_w;
    logic                            ack_w;
    logic [TIME_W-1:0]               alarm_val_w;
    logic [NUM_EVT-1:0]              clr_w;
    logic [NUM_EVT-1:0]              flag_w;
    logic [NUM_EVT-1:0][TIME_W-1:0]  cap_w;

    tod_regs #(
        .BUS_W(BUS_W), .TICK_W(TICK_W), .NUM_EVT(NUM_EVT),
        .ADDEND_RST(ADDEND_RST), .TICK_RST(TICK_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .time_now(time_ns), .alarm_val(alarm_val_w), .alarm_fired(alarm_irq),
        .caps(cap_w), .flags(flag_w),
        .addend_q(addend_w), .tick_q(tick_w),
        .load_en(load_en_w), .load_val(load_val_w),
        .arm(arm_w), .arm_val(arm_val_w), .ack(ack_w), .evt_clr(clr_w)
    );

    tod_phase_accum #(
        .ACC_W(ACC_W), .TIME_W(TIME_W), .TICK_W(TICK_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .addend(addend_w), .tick(tick_w),
        .load_en(load_en_w), .load_val(load_val_w), .time_q(time_ns)
    );

    tod_alarm #(
        .TIME_W(TIME_W)
    ) u_alarm (
        .clk(clk), .rst_n(rst_n), .arm(arm_w), .arm_val(arm_val_w),
        .ack(ack_w), .time_now(time_ns), .alarm_q(alarm_val_w),
        .fired(alarm_irq)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        tod_event_capture #(
            .TIME_W(TIME_W), .SYNC_N(2)
        ) u_cap (
            .clk(clk), .rst_n(rst_n), .evt_in(evt_in[g]),
            .time_now(time_ns), .clr(clr_w[g]),
            .cap_q(cap_w[g]), .flag_q(flag_w[g])
        );
    end
endmodule

// File: rtl/tod_checker.sv
module tod_checker
    import tod_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int TICK_W  = 8,
    parameter int NUM_EVT = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [BUS_W-1:0]     wdata,
    input logic [2*BUS_W-1:0]   time_ns,
    input logic                 alarm_irq,
    input logic [TICK_W-1:0]    tick,
    input logic [2*BUS_W-1:0]   load_val,
    input logic [2*BUS_W-1:0]   alarm_val,
    input logic [NUM_EVT-1:0]   flags
);
    localparam int TIME_W = 2 * BUS_W;

    logic load_wr, arm_wr, ack_wr;
    assign load_wr = wr_en && (addr == RA_TIME_HI);
    assign arm_wr  = wr_en && (addr == RA_ALARM_HI);
    assign ack_wr  = wr_en && (addr == RA_STATUS) && wdata[NUM_EVT];

    a_r2_step_or_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_wr |=> (time_ns == $past(time_ns)) ||
                     (time_ns == $past(time_ns) + TIME_W'($past(tick))));

    a_r5_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> time_ns == $past(load_val));

    a_r9_fire_reason: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(time_ns) >= $past(alarm_val));

    a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && !arm_wr && !ack_wr) |=> alarm_irq);

    a_r10_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && ack_wr && !arm_wr) |=> !alarm_irq);

    a_r11_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> !alarm_irq);

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
        a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !(wr_en && addr == RA_STATUS && wdata[g])) |=> flags[g]);
    end
endmodule

bind tod_addend_counter tod_checker #(
    .BUS_W(BUS_W), .TICK_W(TICK_W), .NUM_EVT(NUM_EVT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .time_ns(time_ns), .alarm_irq(alarm_irq), .tick(tick_w),
    .load_val(load_val_w), .alarm_val(alarm_val_w), .flags(flag_w)
);

// File: tb/sim_tod_addend_counter.sv
module sim_tod_addend_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  evt_in = '0;
    logic [63:0] time_ns;
    logic        alarm_irq;

    int checks = 0;
    int failures = 0;
    bit run_cmp = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tod_addend_counter u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_in(evt_in),
        .time_ns(time_ns), .alarm_irq(alarm_irq)
    );

    // behavioural reference model
    longint unsigned m_acc, m_time, m_add, m_tick, m_ldlo, m_allo, m_alarm, m_snap;
    int              m_st;
    bit [2:0]        m_sync [2];
    longint unsigned m_cap [2];
    bit              m_flag [2];

    always @(posedge clk) begin
        longint unsigned sum, t_old;
        bit ge;
        if (!rst_n) begin
            m_acc = 0; m_time = 0; m_add = 64'h9999_99A4; m_tick = 10;
            m_ldlo = 0; m_allo = 0; m_alarm = 0; m_snap = 0; m_st = 0;
            for (int i = 0; i < 2; i++) begin
                m_sync[i] = 0; m_cap[i] = 0; m_flag[i] = 0;
            end
        end else begin
            t_old = m_time;
            ge = (t_old >= m_alarm);
            if (wr_en && addr == 4'h3) begin
                m_time = {wdata, m_ldlo[31:0]};
                m_acc = 0;
            end else begin
                sum = m_acc + m_add;
                if (sum >= 64'h1_0000_0000) m_time = m_time + m_tick;
                m_acc = sum & 64'hFFFF_FFFF;
            end
            if (wr_en && addr == 4'h5) begin
                m_st = 1; m_alarm = {wdata, m_allo[31:0]};
            end else if (m_st == 1 && ge) m_st = 2;
            else if (m_st == 2 && wr_en && addr == 4'h6 && wdata[2]) m_st = 0;
            for (int i = 0; i < 2; i++) begin
                if (m_sync[i][1] && !m_sync[i][2]) begin
                    m_cap[i] = t_old; m_flag[i] = 1;
                end else if (wr_en && addr == 4'h6 && wdata[i]) m_flag[i] = 0;
                m_sync[i] = {m_sync[i][1:0], evt_in[i]};
            end
            if (rd_en && addr == 4'h2) m_snap = t_old >> 32;
            if (wr_en && addr == 4'h0) m_add = wdata;
            if (wr_en && addr == 4'h1) m_tick = wdata[7:0];
            if (wr_en && addr == 4'h2) m_ldlo = wdata;
            if (wr_en && addr == 4'h4) m_allo = wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run_cmp) begin
            chk(time_ns == m_time, "R2 time vs model", time_ns, m_time);
            chk(alarm_irq == (m_st == 2), "R9 irq vs model", alarm_irq, m_st == 2);
        end
    end

    // both tasks are called at a negedge and return at the next negedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        logic [63:0] t_obs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_cmp = 1'b1;
        chk(time_ns == 0, "R1 time after reset", time_ns, 0);
        chk(alarm_irq == 0, "R1 irq after reset", alarm_irq, 0);

        // R2: 40 cycles at the reset addend give floor(40*add/2^32) ticks
        repeat (40) @(negedge clk);
        chk(time_ns == 64'd240, "R2 tick count after 40 cycles", time_ns, 240);

        rd(4'h0, v); chk(v == 32'h9999_99A4, "R1 addend reset", v, 32'h9999_99A4);
        rd(4'h1, v); chk(v == 10, "R1 tick reset", v, 10);
        rd(4'h6, v); chk(v == 0, "R1 status reset", v, 0);

        // R4 / R5: half-rate addend, 5 ns tick, load zero
        wr(4'h1, 32'd5);
        wr(4'h0, 32'h8000_0000);
        wr(4'h2, 32'h0);
        wr(4'h3, 32'h0);
        chk(time_ns == 0, "R5 load zero", time_ns, 0);
        repeat (10) @(negedge clk);
        chk(time_ns == 25, "R4 five ticks of 5 ns", time_ns, 25);

        // R3: remainder survives an addend change
        wr(4'h0, 32'hC000_0000);
        wr(4'h3, 32'h0);
        wr(4'h0, 32'h4000_0000);
        @(negedge clk);
        chk(time_ns == 5, "R3 carry from kept remainder", time_ns, 5);
        repeat (4) @(negedge clk);
        chk(time_ns == 10, "R3 new addend rate", time_ns, 10);

        // R5: full 64-bit load
        wr(4'h2, 32'h9ABC_DEF0);
        wr(4'h3, 32'h1234_5678);
        chk(time_ns == 64'h1234_5678_9ABC_DEF0, "R5 atomic load", time_ns,
            64'h1234_5678_9ABC_DEF0);

        // R6: coherent read across a low-word wrap
        wr(4'h1, 32'd10);
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'h2, 32'hFFFF_FFF0);
        wr(4'h3, 32'h1);
        rd(4'h2, v); chk(v == 32'hFFFF_FFF0, "R6 low word read", v, 32'hFFFF_FFF0);
        repeat (4) @(negedge clk);
        chk(time_ns[63:32] == 2, "R6 time carried into high word", time_ns[63:32], 2);
        rd(4'h3, v); chk(v == 1, "R6 frozen high word", v, 1);

        // R7: event 0 capture through the synchronizer
        wr(4'h0, 32'h8000_0000);
        evt_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        t_obs = time_ns;
        @(negedge clk);
        rd(4'h8, v); chk(v == t_obs[31:0], "R7 capture low", v, t_obs[31:0]);
        rd(4'h9, v); chk(v == t_obs[63:32], "R7 capture high", v, t_obs[63:32]);
        repeat (20) @(negedge clk);
        rd(4'h8, v); chk(v == t_obs[31:0], "R7 held level no recapture", v, t_obs[31:0]);
        rd(4'h6, v); chk(v == 1, "R7 status flag 0", v, 1);
        evt_in[1] = 1'b1;
        @(negedge clk);
        evt_in[1] = 1'b0;
        repeat (4) @(negedge clk);
        rd(4'hA, v); chk(v == m_cap[1][31:0], "R7 capture event 1", v, m_cap[1][31:0]);
        rd(4'h6, v); chk(v == 3, "R7 both flags", v, 3);

        // R8: write-one-to-clear per flag
        wr(4'h6, 32'h1);
        rd(4'h6, v); chk(v == 2, "R8 clear flag 0 only", v, 2);
        evt_in[0] = 1'b0;

        // R9: alarm at exact boundary
        wr(4'h2, 32'd1000);
        wr(4'h3, 32'h0);
        wr(4'h4, 32'd1100);
        wr(4'h5, 32'h0);
        chk(alarm_irq == 0, "R9 armed not fired", alarm_irq, 0);
        for (int n = 0; n < 200 && time_ns < 1100; n++) @(negedge clk);
        chk(alarm_irq == 0, "R9 no fire before compare", alarm_irq, 0);
        @(negedge clk);
        chk(alarm_irq == 1, "R9 fired at reach", alarm_irq, 1);
        rd(4'h6, v); chk(v[2] == 1, "R9 status bit 2", v[2], 1);

        // R10: acknowledge, no second fire
        wr(4'h6, 32'h4);
        chk(alarm_irq == 0, "R10 ack lowers irq", alarm_irq, 0);
        repeat (10) @(negedge clk);
        chk(alarm_irq == 0, "R10 no re-fire", alarm_irq, 0);

        // R11: re-arm in the past, then re-arm while fired
        wr(4'h4, 32'd50);
        wr(4'h5, 32'h0);
        chk(alarm_irq == 0, "R11 armed past value", alarm_irq, 0);
        @(negedge clk);
        chk(alarm_irq == 1, "R11 past value fires next cycle", alarm_irq, 1);
        wr(4'h5, 32'hFFFF);
        chk(alarm_irq == 0, "R11 arm clears irq", alarm_irq, 0);
        repeat (10) @(negedge clk);
        chk(alarm_irq == 0, "R11 far alarm stays quiet", alarm_irq, 0);
        rd(4'h5, v); chk(v == 32'hFFFF, "R11 alarm high readback", v, 32'hFFFF);
        rd(4'h4, v); chk(v == 50, "R11 alarm low readback", v, 50);

        run_cmp = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule